// File: doc/BRIEF.md
# Page-Seeded PRBS-15 Byte Scrambler

This block sits on the raw data path of a NAND flash page and XORs every byte of a page with a pseudorandom mask. The mask comes from a 15-bit linear feedback shift register with feedback polynomial x^15 + x^14 + 1. The register is loaded from a 64-entry seed table, and the entry is selected by the page position inside its erase block. XOR is its own inverse, so one instance serves both the write direction (scrambling) and the read direction (descrambling). Firmware loads every seed table entry through a simple write port. A configuration pin states whether the stored seeds are held in reverse bit order.

A page is handled as a fixed number of equal chunks. The defaults are four chunks of 1088 bytes, which give 4352 bytes per page. At the first byte of every chunk the generator is reloaded with the same page seed, so all chunks of a page see an identical mask. Inside a chunk the generator runs on without a break, including across its own period, which is not a whole number of bytes.

Both byte streams use valid/ready. A byte moves when valid and ready are high at the same rising edge. The output holds its byte and valid while ready is low. A stalled output lowers in_ready, and the generator advances only on accepted bytes, so back-pressure never shifts the mask. A start pulse opens a page. No byte is accepted before it, during it, or after the last byte of the page.

Top module: `nand_page_scrambler`

## Requirements
- R1: Output byte = input byte XOR mask. A mask bit is the XOR of state bits 14 and 13, and the state then shifts left with that bit entering at bit 0. The first of 8 such steps gives mask bit 0 (LSB). The generator advances exactly 8 steps for each accepted input byte.
- R2: On start the seed index is page_addr modulo 64. The table entry is read at that start and then used for the whole page.
- R3: When seed_bitrev is high at start, the entry is bit-reversed before use: bit k of the seed is bit 14-k of the entry.
- R4: Each of the 64 entries is writable through seed_we/seed_waddr/seed_wdata. A write affects every start that comes after its write edge.
- R5: The generator reloads the page seed at the first byte of every chunk (CHUNK_BYTES bytes, default 1088). All CHUNKS chunks (default 4) of a page therefore carry the same mask.
- R6: Within a chunk the generator never restarts on its own, even when the chunk is longer than the 32767-bit period.
- R7: If the selected seed (after optional reversal) is zero, the value 0x0001 is used instead and seed_err goes high. seed_err stays high until reset.
- R8: When bypass is high as a byte is accepted, that byte passes unmasked, and the generator still advances 8 steps.
- R9: While out_valid is high and out_ready is low, out_data and out_valid hold, and in_ready is low.
- R10: out_last is high on the output byte whose index within its chunk is CHUNK_BYTES-1. page_done is a one-cycle pulse in the cycle after the last byte of the page leaves the output.
- R11: After reset, out_valid, in_ready, page_done and seed_err are low. in_ready is low in the start cycle, before the first start, and after the last byte of a page is accepted, until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_we | input | 1 | Seed table write strobe |
| seed_waddr | input | 6 | Seed table entry to write |
| seed_wdata | input | 15 | Seed value to write |
| seed_bitrev | input | 1 | Stored seeds are bit-reversed, sampled at start |
| bypass | input | 1 | Pass bytes unmasked, sampled per accepted byte |
| start | input | 1 | Begin a page, one-cycle pulse |
| page_addr | input | 16 | Page address, sampled at start |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block accepts an input byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Masked output byte |
| out_ready | input | 1 | Sink accepts the output byte |
| out_last | output | 1 | Output byte is the last of its chunk |
| page_done | output | 1 | Pulse after the last byte of a page leaves |
| seed_err | output | 1 | Sticky flag: a zero seed was selected |

## Verification
The checker watches the output handshake on every cycle. It checks that a stalled byte and its valid flag hold and that in_ready stays low under a stall. It also checks that seed_err never falls, that page_done follows only an output transfer marked last, and that page_done lasts one cycle. The correctness of the mask itself can only be shown by the bench scenarios. These cover the chunk reload, the seed index wrap, bit reversal, table rewrites, the zero-seed substitute, bypass with continued stepping, and a chunk longer than the generator period. The bench compares these with a model computed arithmetically.

// File: rtl/nps_pkg.sv
package nps_pkg;

  localparam int LFSR_W = 15;
  localparam int BYTE_W = 8;

  typedef logic [LFSR_W-1:0] lfsr_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // Mirror a seed end for end.
  function automatic lfsr_t rev_bits(input lfsr_t v);
    lfsr_t r;
    for (int i = 0; i < LFSR_W; i++) r[i] = v[LFSR_W-1-i];
    return r;
  endfunction

  // New bit produced by one step (x^15 + x^14 + 1).
  function automatic logic fb_bit(input lfsr_t s);
    return s[LFSR_W-1] ^ s[LFSR_W-2];
  endfunction

  // One shift of the generator.
  function automatic lfsr_t step1(input lfsr_t s);
    return {s[LFSR_W-2:0], fb_bit(s)};
  endfunction

endpackage

// File: rtl/nps_seed_table.sv
module nps_seed_table import nps_pkg::*; #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  lfsr_t            wr_val,
  input  logic [IDX_W-1:0] rd_idx,
  output lfsr_t            rd_val
);

  lfsr_t entry_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entry_q[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        entry_q[g] <= wr_val;
      end
    end
  end

  assign rd_val = entry_q[rd_idx];

endmodule

// File: rtl/nps_mask_gen.sv
module nps_mask_gen import nps_pkg::*; #(
  parameter int    STEPS       = BYTE_W,
  parameter lfsr_t RESET_STATE = lfsr_t'(1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  lfsr_t            load_val,
  input  logic             advance,
  output logic [STEPS-1:0] mask
);

  lfsr_t state_q;
  lfsr_t state_nx;

  // Unrolled walk: bit i of the mask is the bit made by step i.
  always_comb begin
    lfsr_t walk;
    walk = state_q;
    for (int i = 0; i < STEPS; i++) begin
      mask[i] = fb_bit(walk);
      walk    = step1(walk);
    end
    state_nx = walk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RESET_STATE;
    end else if (load) begin
      state_q <= load_val;
    end else if (advance) begin
      state_q <= state_nx;
    end
  end

endmodule

// File: rtl/nps_chunk_ctr.sv
module nps_chunk_ctr #(
  parameter int CHUNK_BYTES = 1088,
  parameter int CHUNKS      = 4,
  localparam int BW = (CHUNK_BYTES > 1) ? $clog2(CHUNK_BYTES) : 1,
  localparam int CW = (CHUNKS > 1) ? $clog2(CHUNKS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic last_byte,
  output logic last_chunk
);

  logic [BW-1:0] byte_q;
  logic [CW-1:0] chunk_q;

  assign last_byte  = (byte_q == BW'(CHUNK_BYTES - 1));
  assign last_chunk = (chunk_q == CW'(CHUNKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q  <= '0;
      chunk_q <= '0;
    end else if (clear) begin
      byte_q  <= '0;
      chunk_q <= '0;
    end else if (step) begin
      if (last_byte) begin
        byte_q  <= '0;
        chunk_q <= last_chunk ? '0 : chunk_q + CW'(1);
      end else begin
        byte_q <= byte_q + BW'(1);
      end
    end
  end

endmodule

// File: rtl/nand_page_scrambler.sv
module nand_page_scrambler import nps_pkg::*; #(
  parameter int    PAGE_AW       = 16,
  parameter int    SEED_DEPTH    = 64,
  parameter int    CHUNK_BYTES   = 1088,
  parameter int    CHUNKS        = 4,
  parameter lfsr_t SEED_FALLBACK = lfsr_t'(1),
  localparam int   IDX_W         = $clog2(SEED_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               seed_we,
  input  logic [IDX_W-1:0]   seed_waddr,
  input  logic [LFSR_W-1:0]  seed_wdata,
  input  logic               seed_bitrev,
  input  logic               bypass,
  input  logic               start,
  input  logic [PAGE_AW-1:0] page_addr,
  input  logic               in_valid,
  input  logic [BYTE_W-1:0]  in_data,
  output logic               in_ready,
  output logic               out_valid,
  output logic [BYTE_W-1:0]  out_data,
  input  logic               out_ready,
  output logic               out_last,
  output logic               page_done,
  output logic               seed_err
);

  // Seed selection
  lfsr_t      tbl_val;
  lfsr_t      seed_oriented;
  lfsr_t      seed_pick;
  logic       seed_zero;
  logic [IDX_W-1:0] rd_idx;

  assign rd_idx = IDX_W'(page_addr % PAGE_AW'(SEED_DEPTH));

  nps_seed_table #(.DEPTH(SEED_DEPTH)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (seed_we),
    .wr_idx (seed_waddr),
    .wr_val (seed_wdata),
    .rd_idx (rd_idx),
    .rd_val (tbl_val)
  );

  assign seed_oriented = seed_bitrev ? rev_bits(tbl_val) : tbl_val;
  assign seed_zero     = (seed_oriented == '0);
  assign seed_pick     = seed_zero ? SEED_FALLBACK : seed_oriented;

  // Control state
  logic  active_q;
  lfsr_t seed_q;
  logic  err_q;
  logic  accept;
  logic  last_byte;
  logic  last_chunk;

  assign in_ready = active_q && !start && (!out_valid || out_ready);
  assign accept   = in_valid && in_ready;

  nps_chunk_ctr #(.CHUNK_BYTES(CHUNK_BYTES), .CHUNKS(CHUNKS)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start),
    .step       (accept),
    .last_byte  (last_byte),
    .last_chunk (last_chunk)
  );

  // Mask generator: loaded at page start and at every chunk boundary.
  logic [BYTE_W-1:0] mask;
  logic              gen_load;
  lfsr_t             gen_val;

  assign gen_load = start || (accept && last_byte);
  assign gen_val  = start ? seed_pick : seed_q;

  nps_mask_gen #(.STEPS(BYTE_W)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (gen_load),
    .load_val (gen_val),
    .advance  (accept),
    .mask     (mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      seed_q   <= SEED_FALLBACK;
      err_q    <= 1'b0;
    end else if (start) begin
      active_q <= 1'b1;
      seed_q   <= seed_pick;
      if (seed_zero) err_q <= 1'b1;
    end else if (accept && last_byte && last_chunk) begin
      active_q <= 1'b0;
    end
  end

  // Output register stage
  logic              ov_q;
  logic [BYTE_W-1:0] od_q;
  logic              ol_q;
  logic              oend_q;
  logic              done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q   <= 1'b0;
      od_q   <= '0;
      ol_q   <= 1'b0;
      oend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= ov_q && out_ready && oend_q;
      if (accept) begin
        ov_q   <= 1'b1;
        od_q   <= bypass ? in_data : (in_data ^ mask);
        ol_q   <= last_byte;
        oend_q <= last_byte && last_chunk;
      end else if (out_ready) begin
        ov_q <= 1'b0;
      end
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_last  = ov_q && ol_q;
  assign page_done = done_q;
  assign seed_err  = err_q;

endmodule

// File: rtl/nps_checks.sv
module nps_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_ready,
  input logic       out_last,
  input logic       page_done,
  input logic       seed_err
);

  p_hold_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  p_hold_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data));

  p_stall_blocks_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seed_err |=> seed_err);

  p_done_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(page_done) |-> $past(out_valid && out_ready && out_last));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    page_done |=> !page_done);

  p_last_with_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

endmodule

bind nand_page_scrambler nps_checks u_chk (.*);

// File: tb/tb_nand_page_scrambler.sv
`timescale 1ns/1ps
module tb_nand_page_scrambler;

  localparam int CB      = 12;
  localparam int NC      = 4;
  localparam int LONG_CB = 4200;
  localparam int FALLBK  = 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        seed_we;
  logic [5:0]  seed_waddr;
  logic [14:0] seed_wdata;
  logic        seed_bitrev, bypass, start;
  logic [7:0]  page_addr;
  logic        in_valid, in_ready, out_valid, out_ready, out_last, page_done, seed_err;
  logic [7:0]  in_data, out_data;

  logic        l_start, l_in_valid, l_in_ready, l_out_valid, l_out_last, l_done, l_err;
  logic [7:0]  l_in_data, l_out_data;

  nand_page_scrambler #(.PAGE_AW(8), .CHUNK_BYTES(CB), .CHUNKS(NC)) dut (
    .clk(clk), .rst_n(rst_n), .seed_we(seed_we), .seed_waddr(seed_waddr),
    .seed_wdata(seed_wdata), .seed_bitrev(seed_bitrev), .bypass(bypass),
    .start(start), .page_addr(page_addr), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .out_last(out_last), .page_done(page_done),
    .seed_err(seed_err));

  nand_page_scrambler #(.PAGE_AW(8), .CHUNK_BYTES(LONG_CB), .CHUNKS(1)) dut_long (
    .clk(clk), .rst_n(rst_n), .seed_we(seed_we), .seed_waddr(seed_waddr),
    .seed_wdata(seed_wdata), .seed_bitrev(seed_bitrev), .bypass(bypass),
    .start(l_start), .page_addr(page_addr), .in_valid(l_in_valid), .in_data(l_in_data),
    .in_ready(l_in_ready), .out_valid(l_out_valid), .out_data(l_out_data),
    .out_ready(1'b1), .out_last(l_out_last), .page_done(l_done),
    .seed_err(l_err));

  int checks = 0;
  int errors = 0;
  int tbl [64];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int rev15(input int v);
    int r = 0;
    for (int i = 0; i < 15; i++) if ((v >> i) & 1) r |= 1 << (14 - i);
    return r;
  endfunction

  function automatic int eff_seed(input int idx, input bit rev);
    int s = rev ? rev15(tbl[idx]) : tbl[idx];
    return (s == 0) ? FALLBK : s;
  endfunction

  // Mask bits from 8 generator steps starting at state s.
  function automatic int mask8(input int s);
    int m = 0;
    int t = s;
    for (int i = 0; i < 8; i++) begin
      int b = ((t >> 14) ^ (t >> 13)) & 1;
      m |= b << i;
      t = ((t << 1) | b) & 32'h7FFF;
    end
    return m;
  endfunction

  function automatic int adv8(input int s);
    int t = s;
    for (int i = 0; i < 8; i++) t = ((t << 1) | (((t >> 14) ^ (t >> 13)) & 1)) & 32'h7FFF;
    return t;
  endfunction

  function automatic int data_of(input int a, input int k);
    return (a * 29 + k * 71 + 5) & 255;
  endfunction

  task automatic write_seed(input int i, input int v);
    @(negedge clk);
    seed_we = 1'b1; seed_waddr = 6'(i); seed_wdata = 15'(v);
    @(negedge clk);
    seed_we = 1'b0;
    tbl[i] = v;
  endtask

  task automatic run_page(input int addr, input bit rev, input bit byp,
                          input int stall, input string tag);
    int seed, ms, nin, nout, cyc, total, exp, pos;
    bit hold;
    int hold_d;
    string req;
    total = CB * NC;
    @(negedge clk);
    page_addr = 8'(addr); seed_bitrev = rev; bypass = byp;
    start = 1'b1; in_valid = 1'b1; in_data = 8'h00; out_ready = 1'b1;
    #1;
    check(in_ready == 1'b0, "R11", "in_ready during start", int'(in_ready), 0);
    @(negedge clk);
    start = 1'b0;
    seed = eff_seed(addr % 64, rev);
    ms = seed; nin = 0; nout = 0; cyc = 0; hold = 0; hold_d = 0;
    while (nout < total && cyc < 4000) begin
      out_ready = (stall == 0) ? 1'b1 : ((cyc % stall) != 0);
      in_valid  = (nin < total) && ((stall == 0) || ((cyc % 3) != 1));
      in_data   = 8'(data_of(addr, nin));
      #1;
      if (hold) begin
        check(out_valid && (int'(out_data) == hold_d), "R9", "held byte",
              int'(out_data), hold_d);
        check(in_ready == 1'b0 || out_ready, "R9", "ready under stall", int'(in_ready), 0);
      end
      hold = out_valid && !out_ready;
      hold_d = int'(out_data);
      if (out_valid && out_ready) begin
        pos = nout % CB;
        if (pos == 0) ms = seed;
        exp = byp ? data_of(addr, nout) : (data_of(addr, nout) ^ mask8(ms));
        ms = adv8(ms);
        if (tag != "") req = tag;
        else if (byp) req = "R8";
        else if (nout >= CB) req = "R5";
        else if (rev) req = "R3";
        else if (addr >= 64) req = "R2";
        else req = "R1";
        check(int'(out_data) == exp, req, "out_data", int'(out_data), exp);
        check(out_last == (pos == CB - 1), "R10", "out_last", int'(out_last),
              int'(pos == CB - 1));
        nout++;
      end
      if (in_valid && in_ready) nin++;
      @(negedge clk);
      cyc++;
    end
    in_valid = 1'b0;
    #1;
    check(page_done == 1'b1, "R10", "page_done after final byte", int'(page_done), 1);
    check(in_ready == 1'b0, "R11", "in_ready after page", int'(in_ready), 0);
    @(negedge clk);
    #1;
    check(page_done == 1'b0, "R10", "page_done one cycle", int'(page_done), 0);
  endtask

  task automatic run_long(input int addr);
    int ms, nin, nout, cyc, exp;
    @(negedge clk);
    page_addr = 8'(addr); seed_bitrev = 1'b0; bypass = 1'b0; l_start = 1'b1;
    @(negedge clk);
    l_start = 1'b0;
    ms = eff_seed(addr % 64, 1'b0);
    nin = 0; nout = 0; cyc = 0;
    while (nout < LONG_CB && cyc < LONG_CB + 100) begin
      l_in_valid = (nin < LONG_CB);
      l_in_data  = 8'(nin & 255);
      #1;
      if (l_out_valid) begin
        exp = (nout & 255) ^ mask8(ms);
        ms = adv8(ms);
        check(int'(l_out_data) == exp, "R6", "long chunk byte", int'(l_out_data), exp);
        nout++;
      end
      if (l_in_valid && l_in_ready) nin++;
      @(negedge clk);
      cyc++;
    end
    l_in_valid = 1'b0;
    check(nout == LONG_CB, "R6", "long chunk byte count", nout, LONG_CB);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; seed_we = 1'b0; seed_waddr = '0; seed_wdata = '0;
    seed_bitrev = 1'b0; bypass = 1'b0; start = 1'b0; page_addr = '0;
    in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    l_start = 1'b0; l_in_valid = 1'b0; l_in_data = '0;
    for (int i = 0; i < 64; i++) tbl[i] = 0;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R11", "reset out_valid", int'(out_valid), 0);
    check(in_ready == 1'b0, "R11", "reset in_ready", int'(in_ready), 0);
    check(page_done == 1'b0, "R11", "reset page_done", int'(page_done), 0);
    check(seed_err == 1'b0, "R11", "reset seed_err", int'(seed_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    in_valid = 1'b1;
    #1;
    check(in_ready == 1'b0, "R11", "in_ready before first start", int'(in_ready), 0);
    in_valid = 1'b0;

    for (int i = 0; i < 64; i++) write_seed(i, (i * 977 + 123) & 32'h7FFF);

    // Sweep all seed indices, plain and reversed, with varied stall patterns.
    for (int a = 0; a < 128; a++)
      run_page(a, a >= 64, (a % 7) == 3, ((a % 4) == 0) ? 0 : (a % 4) + 1, "");

    // R4: rewrite one entry and confirm the new seed is used.
    write_seed(22, 32'h1357);
    run_page(22, 1'b0, 1'b0, 0, "R4");
    run_page(86, 1'b1, 1'b0, 3, "R4");

    // R7: zero seed gives the substitute value and a sticky flag.
    check(seed_err == 1'b0, "R7", "seed_err before zero seed", int'(seed_err), 0);
    write_seed(9, 0);
    run_page(9, 1'b0, 1'b0, 2, "R7");
    check(seed_err == 1'b1, "R7", "seed_err after zero seed", int'(seed_err), 1);
    run_page(10, 1'b0, 1'b0, 0, "R7");
    check(seed_err == 1'b1, "R7", "seed_err stays set", int'(seed_err), 1);

    // R6: a chunk longer than the generator period.
    run_long(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule